// File: doc/BRIEF.md
# Bidirectional GPIO Port with Change Interrupt

This block is an eight-pin general-purpose I/O port. Each pin has its own direction bit and output latch bit. The pad controls it produces are output enable, output value and weak pull-up enable. Software reaches the port through a small register interface: it can read the pins, read or write the latch, set the direction and use a control register. One global active-low bit in the control register turns on the weak pull-ups of every pin that is an input. A pull-up is never active on a pin that is driving.

The upper four pins can raise a change interrupt. Every port access takes a snapshot of the synchronized pin levels. Each of these upper pins that is an input is then compared with its snapshot bit. Any difference sets a sticky flag for the interrupt controller. The flag stays set for as long as the mismatch exists, so software has to access the port before a clear will hold. Pins 4 down to 1 can also be taken over by a display segment driver. While a pin's segment enable is set, the segment logic controls its pad and the pin drops out of the I/O and change functions.

Register map (2-bit address): 0 is the pin register, 1 is the output latch, 2 is the direction register and 3 is the control register. In the control register, bit 7 is the pull-up disable (active low) and bit 0 is the change flag.

Top module: `gpio_chg_port`

## Requirements
- R1: A direction bit of 1 makes the pin an input: pad_oe is 0 for that pin. A direction bit of 0 sets pad_oe to 1 and drives the latch bit onto pad_out. The direction register is written at address 2, and the new value reaches the pads one cycle after the write.
- R2: A write to address 0 or address 1 loads the output latch. A read of address 1 returns the latch contents. A read of address 0 returns the pin levels after a two-flop synchronizer. These two reads are independent, so a pin whose level differs from its latch bit reads back differently at the two addresses.
- R3: pad_pu for a pin equals its direction bit AND NOT control bit 7. This means the pull-ups are active only when control bit 7 is 0, and only on input pins.
- R4: After reset the direction register is 0xFF, the latch is 0x00, the control register reads 0x80, the snapshot is 0, and pad_oe, pad_pu and chg_irq are all 0.
- R5: When an input pin among pins 7..4 differs from its snapshot bit, the change flag is set. The flag appears on chg_irq and in control bit 0 no later than the third clock edge after the pad changes.
- R6: Pins 3..0 never set the change flag. A pin among 7..4 whose direction bit is 0 also never sets it. If that pin later becomes an input, it is compared again.
- R7: A read or write of address 0 loads the snapshot. Writing 0 to control bit 0 clears the flag. If a mismatch is present in the same cycle as the clear, the set wins, so the clear has no effect until a port access has ended the mismatch.
- R8: While seg_en[k] is 1, pin k+1 has pad_oe = 1, pad_out = seg_drv[k] and pad_pu = 0. That pin reads as 0 at address 0 and does not take part in change detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from addr) |
| pad_in | input | 8 | Pad input levels |
| pad_oe | output | 8 | Pad output enable, 1 = drive |
| pad_out | output | 8 | Pad output value |
| pad_pu | output | 8 | Weak pull-up enable |
| seg_en | input | 4 | Segment ownership of pins 4..1 |
| seg_drv | input | 4 | Segment drive values of pins 4..1 |
| chg_irq | output | 1 | Sticky change flag |

## Verification
A wrong snapshot or a wrong eligibility mask shows up on chg_irq. It appears either as a flag that rises three edges after a pin change that should have been ignored, or as a flag that never rises. Direction, latch or pull-up state that is wrong appears on pad_oe, pad_out or pad_pu in the cycle after the write. A flag that drops while a mismatch persists is visible right after the clear write, because chg_irq reads 0 in the next cycle when it should stay 1.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  typedef enum logic [1:0] {
    SEL_PINS  = 2'd0,
    SEL_LATCH = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_CTRL  = 2'd3
  } gpio_sel_e;

  localparam int CTRL_PU_N_BIT = 7;
  localparam int CTRL_FLAG_BIT = 0;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_q_n <= stage_q;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int W      = 8,
  parameter int SEG_LO = 1,
  parameter int SEG_W  = 4
) (
  input  logic [W-1:0]     dir,
  input  logic [W-1:0]     lat,
  input  logic             pu_n,
  input  logic [SEG_W-1:0] seg_en,
  input  logic [SEG_W-1:0] seg_drv,
  output logic [W-1:0]     seg_own,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (i >= SEG_LO && i < SEG_LO + SEG_W) begin : g_shared
      assign seg_own[i] = seg_en[i-SEG_LO];
      assign pad_oe[i]  = seg_en[i-SEG_LO] | ~dir[i];
      assign pad_out[i] = seg_en[i-SEG_LO] ? seg_drv[i-SEG_LO] : lat[i];
      assign pad_pu[i]  = ~seg_en[i-SEG_LO] & dir[i] & ~pu_n;
    end else begin : g_plain
      assign seg_own[i] = 1'b0;
      assign pad_oe[i]  = ~dir[i];
      assign pad_out[i] = lat[i];
      assign pad_pu[i]  = dir[i] & ~pu_n;
    end
  end
endmodule

// File: rtl/gpio_chg_detect.sv
module gpio_chg_detect #(
  parameter int W      = 8,
  parameter int CHG_LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         snap_load,
  input  logic [W-1:0] pins,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] seg_own,
  output logic         mismatch
);
  localparam int CW = W - CHG_LO;

  logic [CW-1:0] snap_q, snap_d;
  logic [CW-1:0] eligible;

  always_comb begin
    snap_d = snap_q;
    if (snap_load) snap_d = pins[W-1:CHG_LO];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign eligible = dir[W-1:CHG_LO] & ~seg_own[W-1:CHG_LO];
  assign mismatch = |((pins[W-1:CHG_LO] ^ snap_q) & eligible);
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port #(
  parameter int W      = 8,
  parameter int CHG_LO = 4,
  parameter int SEG_LO = 1,
  parameter int SEG_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  input  logic [W-1:0]     pad_in,
  output logic [W-1:0]     pad_oe,
  output logic [W-1:0]     pad_out,
  output logic [W-1:0]     pad_pu,
  input  logic [SEG_W-1:0] seg_en,
  input  logic [SEG_W-1:0] seg_drv,
  output logic             chg_irq
);
  import gpio_chg_pkg::*;

  gpio_sel_e    sel;
  logic         rst_q_n;
  logic [W-1:0] pins_s;
  logic [W-1:0] seg_own;
  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] dir_q, dir_d;
  logic         pu_n_q, pu_n_d;
  logic         flag_q, flag_d;
  logic         lat_en, dir_en, ctrl_en, snap_load, mismatch;

  assign sel = gpio_sel_e'(addr);

  gpio_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  gpio_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_q_n), .d(pad_in), .q(pins_s)
  );

  gpio_pad_ctrl #(.W(W), .SEG_LO(SEG_LO), .SEG_W(SEG_W)) u_pad (
    .dir(dir_q), .lat(lat_q), .pu_n(pu_n_q), .seg_en(seg_en),
    .seg_drv(seg_drv), .seg_own(seg_own), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu)
  );

  gpio_chg_detect #(.W(W), .CHG_LO(CHG_LO)) u_chg (
    .clk(clk), .rst_n(rst_q_n), .snap_load(snap_load), .pins(pins_s),
    .dir(dir_q), .seg_own(seg_own), .mismatch(mismatch)
  );

  // decode
  assign lat_en    = wr_en && (sel == SEL_PINS || sel == SEL_LATCH);
  assign dir_en    = wr_en && (sel == SEL_DIR);
  assign ctrl_en   = wr_en && (sel == SEL_CTRL);
  assign snap_load = (wr_en || rd_en) && (sel == SEL_PINS);

  always_comb begin
    lat_d  = lat_q;
    dir_d  = dir_q;
    pu_n_d = pu_n_q;
    flag_d = flag_q;
    if (lat_en) lat_d = wdata;
    if (dir_en) dir_d = wdata;
    if (ctrl_en) begin
      pu_n_d = wdata[CTRL_PU_N_BIT];
      if (!wdata[CTRL_FLAG_BIT]) flag_d = 1'b0;
    end
    if (mismatch) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      lat_q  <= '0;
      dir_q  <= '1;
      pu_n_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      dir_q  <= dir_d;
      pu_n_q <= pu_n_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_PINS:  rdata = pins_s & ~seg_own;
      SEL_LATCH: rdata = lat_q;
      SEL_DIR:   rdata = dir_q;
      SEL_CTRL: begin
        rdata[CTRL_PU_N_BIT] = pu_n_q;
        rdata[CTRL_FLAG_BIT] = flag_q;
      end
    endcase
  end

  assign chg_irq = flag_q;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk #(
  parameter int W      = 8,
  parameter int SEG_LO = 1,
  parameter int SEG_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [W-1:0]     wdata,
  input logic [SEG_W-1:0] seg_en,
  input logic [W-1:0]     pad_oe,
  input logic [W-1:0]     pad_out,
  input logic [W-1:0]     pad_pu,
  input logic             chg_irq
);
  logic [W-1:0] seg_mask;

  always_comb begin
    seg_mask = '0;
    for (int k = 0; k < SEG_W; k++) seg_mask[SEG_LO+k] = seg_en[k];
  end

  AST_PU_NOT_ON_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);  // R3

  AST_SEG_DRIVES_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & seg_mask) == seg_mask);  // R8

  AST_DIR_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && $stable(seg_en)) |=>
      ((pad_oe & ~seg_mask) == (~$past(wdata) & ~seg_mask)));  // R1

  AST_LATCH_TO_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && $stable(seg_en)) |=>
      ((pad_out & ~seg_mask) == ($past(wdata) & ~seg_mask)));  // R2

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_irq && !(wr_en && addr == 2'd3 && !wdata[0])) |=> chg_irq);  // R7
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.W(W), .SEG_LO(SEG_LO), .SEG_W(SEG_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .seg_en(seg_en), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu),
  .chg_irq(chg_irq)
);

// File: tb/gpio_chg_port_tb_top.sv
module gpio_chg_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_oe, pad_out, pad_pu;
  logic [3:0] seg_en = '0;
  logic [3:0] seg_drv = '0;
  logic       chg_irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  pu_n = 1'b1;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  gpio_chg_port dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .pad_pu(pad_pu), .seg_en(seg_en), .seg_drv(seg_drv),
    .chg_irq(chg_irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic rearm();
    logic [7:0] d;
    settle();
    rd(2'd0, d);
    wr(2'd3, {pu_n, 7'b0});
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd2, d); check("R4 dir", d, 8'hFF);
    rd(2'd1, d); check("R4 latch", d, 8'h00);
    rd(2'd3, d); check("R4 ctrl", d, 8'h80);
    check("R4 pad_oe", pad_oe, 8'h00);
    check("R4 pad_pu", pad_pu, 8'h00);
    check("R4 chg_irq", {7'b0, chg_irq}, 8'h00);
  endtask

  task automatic t_dir_latch();
    logic [7:0] d;
    wr(2'd2, 8'hF0);
    wr(2'd1, 8'h5A);
    check("R1 pad_oe", pad_oe, 8'h0F);
    check("R1 pad_out", pad_out, 8'h5A);
    pad_in = 8'hC3;
    settle();
    rd(2'd1, d); check("R2 latch read", d, 8'h5A);
    rd(2'd0, d); check("R2 pin read", d, 8'hC3);
    wr(2'd0, 8'hA5);
    check("R2 port write loads latch", pad_out, 8'hA5);
    wr(2'd2, 8'hFF);
    check("R1 all inputs", pad_oe, 8'h00);
    pad_in = 8'h00;
    rearm();
  endtask

  task automatic t_pullup();
    pu_n = 1'b0;
    wr(2'd3, 8'h00);
    check("R3 all pulled", pad_pu, 8'hFF);
    wr(2'd2, 8'h0F);
    check("R3 drivers unpulled", pad_pu, 8'h0F);
    pu_n = 1'b1;
    wr(2'd3, 8'h80);
    check("R3 global off", pad_pu, 8'h00);
    wr(2'd2, 8'hFF);
    rearm();
  endtask

  task automatic t_change();
    logic [7:0] d;
    pad_in = 8'h04;
    settle();
    check("R6 low pin ignored", {7'b0, chg_irq}, 8'h00);
    pad_in = 8'h24;
    repeat (3) @(posedge clk);
    #1 check("R5 flag by 3rd edge", {7'b0, chg_irq}, 8'h01);
    rd(2'd3, d); check("R5 ctrl flag bit", d & 8'h01, 8'h01);
    wr(2'd3, 8'h80);
    check("R7 set wins over clear", {7'b0, chg_irq}, 8'h01);
    rd(2'd0, d);
    wr(2'd3, 8'h80);
    settle();
    check("R7 clear holds after access", {7'b0, chg_irq}, 8'h00);
  endtask

  task automatic t_output_excluded();
    wr(2'd2, 8'h7F);
    rearm();
    pad_in[7] = 1'b1;
    settle();
    check("R6 output pin excluded", {7'b0, chg_irq}, 8'h00);
    wr(2'd2, 8'hFF);
    settle();
    check("R6 re-eligible as input", {7'b0, chg_irq}, 8'h01);
    rearm();
  endtask

  task automatic t_segment();
    logic [7:0] d;
    pu_n = 1'b0;
    wr(2'd3, 8'h00);
    seg_en = 4'b1001; seg_drv = 4'b1111;
    #1;
    check("R8 pad_oe", pad_oe, 8'h12);
    check("R8 pad_out", pad_out & 8'h12, 8'h12);
    check("R8 pad_pu", pad_pu, 8'hED);
    pad_in = 8'hFF;
    settle();
    rd(2'd0, d); check("R8 pin read masked", d, 8'hED);
    wr(2'd3, 8'h00);
    pad_in = 8'hEF;
    settle();
    check("R8 segment pin excluded", {7'b0, chg_irq}, 8'h00);
    seg_en = 4'b0000;
    pu_n = 1'b1;
    wr(2'd3, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir_latch();
    t_pullup();
    t_change();
    t_output_excluded();
    t_segment();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule